// File: doc/BRIEF.md
# Minute-Resolution Alarm Matcher

This block watches a running BCD calendar (seconds, minutes, hours, day of month, weekday) and raises an alarm when the time matches a programmed pattern. Four byte-wide alarm registers hold the target minute, hour, date and weekday. Bit 7 of each register is an active-low enable, so software chooses which fields take part. A field whose enable bit is set is ignored.

The comparison runs once per minute, in the cycle where the seconds value turns to 00. If every enabled field matches then, a sticky alarm flag is set. The interrupt output is raised while the flag is set and the alarm interrupt enable is on. Software clears the flag by writing a zero to its bit. The block sits beside the timekeeper on the same byte register port. It has no second-level resolution and no month or year fields.

Top module: `alarm_matcher`

## Requirements
- R1: After a synchronous active-low reset, the following hold: the alarm flag is 0, the interrupt enable is 0, `alarm_irq` is low, and all four alarm registers read 0x80 (every field disabled).
- R2: The register map is as follows. Address 0x0A is minute, 0x0B is hour, 0x0C is date and 0x0D is weekday, and each reads back the full written byte. Address 0x00 holds the interrupt enable in bit 1. Address 0x01 holds the alarm flag in bit 3. All other bits of 0x00 and 0x01 read 0.
- R3: Bit 7 of an alarm register is an active-low field enable. A field with bit 7 = 0 must equal the calendar value for a match. A field with bit 7 = 1 is ignored whatever the calendar holds.
- R4: The compared bits are minute [6:0] against `cal_min`, hour [5:0] against `cal_hour`, date [5:0] against `cal_date`, and weekday [2:0] against `cal_wday`. Register bits outside these ranges (apart from bit 7) take no part.
- R5: The match is evaluated only in a cycle where `cal_sec` is 0x00 and was nonzero in the previous cycle. The flag becomes 1 at the following clock edge. The seconds value is never compared against any register.
- R6: While `cal_sec` stays at 0x00, and while the seconds advance within a matching minute, no further evaluation occurs. A flag cleared inside the matching minute therefore stays clear.
- R7: When all four enable bits are 1, the flag is never set.
- R8: The flag is sticky. Writing 0x01 with bit 3 = 0 clears it. Writing bit 3 = 1 leaves it unchanged. When a match and a clearing write fall in the same cycle, the flag ends up set.
- R9: `alarm_irq` is high exactly when the flag is 1 and the interrupt enable is 1. It follows either one's change from the same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cal_sec | input | 7 | Calendar seconds, BCD |
| cal_min | input | 7 | Calendar minutes, BCD |
| cal_hour | input | 6 | Calendar hours, BCD |
| cal_date | input | 6 | Calendar day of month, BCD |
| cal_wday | input | 3 | Calendar weekday |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
The matcher is driven through minute rollovers under several patterns. These are a single enabled minute field, an enabled hour that differs and then agrees, an hour register carrying an extra bit outside the compared range, and weekday-only and date-only alarms. Together they separate correct per-field masking from comparing too many or too few bits. Seconds are held at zero and then stepped inside a matching minute, which separates an edge-triggered evaluation from a level-triggered one. An all-disabled pattern, a match with the interrupt enable off, and a clear write that lands on the rollover cycle probe the remaining priorities.

// File: rtl/alarm_match_pkg.sv
`timescale 1ns/1ps
// Shared constants for the alarm matcher: register addresses, bit positions
// and the per-field compare widths.
package alarm_match_pkg;
    localparam int DATA_W      = 8;
    localparam int CAL_W       = 7;
    localparam int NUM_FIELDS  = 4;
    localparam int ADDR_CTRL1  = 'h00;
    localparam int ADDR_CTRL2  = 'h01;
    localparam int ADDR_ALARM0 = 'h0A;
    localparam int IE_BIT      = 1;
    localparam int FLAG_BIT    = 3;
    localparam int EN_N_BIT    = 7;
    localparam logic [DATA_W-1:0] CFG_RESET = 8'h80;

    // Number of compared value bits for field idx (0 minute .. 3 weekday).
    function automatic int field_width(input int idx);
        case (idx)
            0:       return 7;
            1:       return 6;
            2:       return 6;
            default: return 3;
        endcase
    endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
`timescale 1ns/1ps
// One alarm field comparator.
// Assumes: cfg holds the active-low enable in bit EN_N_BIT; only the low
// VAL_W bits of cfg and cal_val are compared, the rest are masked off.
module alarm_field_cmp
    import alarm_match_pkg::*;
#(
    parameter int VAL_W = 7
) (
    input  logic [DATA_W-1:0] cfg,
    input  logic [CAL_W-1:0]  cal_val,
    output logic              enabled,
    output logic              hit
);
    localparam logic [CAL_W-1:0] VAL_MASK = CAL_W'((1 << VAL_W) - 1);

    // Field hit: disabled fields always pass, enabled ones must be equal.
    always_comb begin
        enabled = ~cfg[EN_N_BIT];
        hit     = cfg[EN_N_BIT] |
                  ((cfg[CAL_W-1:0] & VAL_MASK) == (cal_val & VAL_MASK));
    end
endmodule

// File: rtl/alarm_minute_tick.sv
`timescale 1ns/1ps
// Minute boundary detector.
// Produces a one-cycle tick when the seconds value turns to zero from a
// nonzero value seen on the previous clock. Assumes seconds are BCD.
module alarm_minute_tick
    import alarm_match_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CAL_W-1:0] sec,
    output logic             tick
);
    logic [CAL_W-1:0] sec_prev;

    // Remember last cycle's seconds value.
    always_ff @(posedge clk) begin
        if (!rst_n) sec_prev <= '0;
        else        sec_prev <= sec;
    end

    // Tick on the transition into second zero.
    always_comb tick = (sec_prev != '0) && (sec == '0);

    // R6
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/alarm_flag.sv
`timescale 1ns/1ps
// Sticky alarm flag.
// Set on a matching minute tick, cleared by software; a set in the same
// cycle as a clear wins so that no alarm event is lost.
module alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic any_en,
    input  logic clr_req,
    output logic flag
);
    // Flag state update with set priority.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= 1'b0;
        else if (tick && match)  flag <= 1'b1;
        else if (clr_req)        flag <= 1'b0;
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);
    // R5
    flag_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !tick) |=> !flag);
    // R7
    flag_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !any_en) |=> !flag);
    // R8
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match && clr_req) |=> flag);
endmodule

// File: rtl/alarm_regfile.sv
`timescale 1ns/1ps
// Register window of the alarm matcher: interrupt enable, flag readback and
// clear request, and the four alarm field registers.
// Assumes single-cycle writes; reads are combinational on the address.
module alarm_regfile
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              flag,
    output logic [DATA_W-1:0] cfg [NUM_FIELDS],
    output logic              irq_en,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(ADDR_CTRL1);
    localparam logic [ADDR_W-1:0] A_CTRL2 = ADDR_W'(ADDR_CTRL2);

    // Interrupt enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                      irq_en <= 1'b0;
        else if (wr && addr == A_CTRL1)  irq_en <= wdata[IE_BIT];
    end

    // One storage byte per alarm field.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_cfg
        localparam logic [ADDR_W-1:0] A_FIELD = ADDR_W'(ADDR_ALARM0 + i);
        // Field register write.
        always_ff @(posedge clk) begin
            if (!rst_n)                      cfg[i] <= CFG_RESET;
            else if (wr && addr == A_FIELD)  cfg[i] <= wdata;
        end
    end

    // Clear request: a zero written to the flag bit.
    always_comb clr_req = wr && (addr == A_CTRL2) && !wdata[FLAG_BIT];

    // Read mux.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL1) rdata[IE_BIT]   = irq_en;
        if (addr == A_CTRL2) rdata[FLAG_BIT] = flag;
        for (int i = 0; i < NUM_FIELDS; i++) begin
            if (addr == ADDR_W'(ADDR_ALARM0 + i)) rdata = cfg[i];
        end
    end
endmodule

// File: rtl/alarm_matcher.sv
`timescale 1ns/1ps
// Minute-resolution alarm matcher top.
// Compares the BCD calendar against four alarm fields once per minute and
// keeps a sticky flag that drives a level interrupt when enabled.
// Assumes calendar inputs are synchronous to clk.
module alarm_matcher
    import alarm_match_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [6:0]        cal_sec,
    input  logic [6:0]        cal_min,
    input  logic [5:0]        cal_hour,
    input  logic [5:0]        cal_date,
    input  logic [2:0]        cal_wday,
    output logic              alarm_irq
);
    logic [DATA_W-1:0]     cfg [NUM_FIELDS];
    logic [CAL_W-1:0]      cal_vec [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] hits;
    logic [NUM_FIELDS-1:0] enables;
    logic                  irq_en, clr_req, flag, tick, any_en, match;

    // Zero-extend calendar fields into a uniform vector.
    always_comb begin
        cal_vec[0] = cal_min;
        cal_vec[1] = {1'b0, cal_hour};
        cal_vec[2] = {1'b0, cal_date};
        cal_vec[3] = {4'b0, cal_wday};
    end

    alarm_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .flag(flag), .cfg(cfg), .irq_en(irq_en),
        .clr_req(clr_req), .rdata(reg_rdata)
    );

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        alarm_field_cmp #(.VAL_W(field_width(i))) u_cmp (
            .cfg(cfg[i]), .cal_val(cal_vec[i]),
            .enabled(enables[i]), .hit(hits[i])
        );
    end

    // Whole-pattern match: all fields pass and at least one is enabled.
    always_comb begin
        any_en = |enables;
        match  = (&hits) && any_en;
    end

    alarm_minute_tick u_tick (
        .clk(clk), .rst_n(rst_n), .sec(cal_sec), .tick(tick)
    );

    alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
        .any_en(any_en), .clr_req(clr_req), .flag(flag)
    );

    // Interrupt level.
    always_comb alarm_irq = flag && irq_en;

    // R9
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !alarm_irq && !(tick && match)) |=> !alarm_irq);
endmodule

// File: tb/alarm_matcher_test.sv
`timescale 1ns/1ps
module alarm_matcher_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [6:0] cal_sec = '0, cal_min = '0;
    logic [5:0] cal_hour = '0, cal_date = '0;
    logic [2:0] cal_wday = '0;
    logic       alarm_irq;

    int  n_checks = 0, n_fail = 0;
    bit  done = 0;

    // Behavioural reference state.
    int  m_cfg [4];
    bit  m_ie, m_flag;
    int  m_prev;
    bit  m_tick, m_all, m_any;
    int  m_cal [4];
    int  m_mask [4] = '{'h7f, 'h3f, 'h3f, 'h07};

    alarm_matcher uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cal_sec(cal_sec),
        .cal_min(cal_min), .cal_hour(cal_hour), .cal_date(cal_date),
        .cal_wday(cal_wday), .alarm_irq(alarm_irq)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model update on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cfg[i]) m_cfg[i] = 'h80;
            m_ie = 0; m_flag = 0; m_prev = 0;
        end else begin
            m_cal[0] = cal_min; m_cal[1] = cal_hour;
            m_cal[2] = cal_date; m_cal[3] = cal_wday;
            m_tick = (m_prev != 0) && (cal_sec == 0);
            m_any = 0; m_all = 1;
            for (int i = 0; i < 4; i++) begin
                if ((m_cfg[i] & 'h80) == 0) begin
                    m_any = 1;
                    if ((m_cfg[i] & m_mask[i]) != m_cal[i]) m_all = 0;
                end
            end
            if (m_tick && m_any && m_all) m_flag = 1;
            else if (reg_wr && reg_addr == 8'h01 && !reg_wdata[3]) m_flag = 0;
            if (reg_wr) begin
                if (reg_addr == 8'h00) m_ie = reg_wdata[1];
                if (reg_addr >= 8'h0A && reg_addr <= 8'h0D) m_cfg[reg_addr - 8'h0A] = reg_wdata;
            end
            m_prev = cal_sec;
        end
    end

    // Cycle-by-cycle comparison of the interrupt level (R9).
    always @(negedge clk) begin
        if (rst_n && !done) check("R9 irq vs model", alarm_irq, m_ie && m_flag);
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 0;
    endtask

    task automatic rd_chk(string tag, input logic [7:0] a, input int exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic set_cal(input logic [6:0] m, input logic [5:0] h,
                           input logic [5:0] d, input logic [2:0] w);
        cal_min = m; cal_hour = h; cal_date = d; cal_wday = w;
    endtask

    task automatic roll();
        cal_sec = 7'h59; cyc();
        cal_sec = 7'h00; cyc();
    endtask

    task automatic setup(input logic [7:0] a0, input logic [7:0] a1,
                         input logic [7:0] a2, input logic [7:0] a3);
        wr(8'h0A, a0); wr(8'h0B, a1); wr(8'h0C, a2); wr(8'h0D, a3);
        wr(8'h01, 8'h00);
    endtask

    initial begin
        repeat (3) cyc();
        // R1 reset state
        check("R1 irq after reset", alarm_irq, 0);
        rd_chk("R1 minute reg reset", 8'h0A, 'h80);
        rd_chk("R1 weekday reg reset", 8'h0D, 'h80);
        rd_chk("R1 flag reset", 8'h01, 'h00);
        rd_chk("R1 enable reset", 8'h00, 'h00);
        rst_n = 1; cyc();

        // R2 register map
        wr(8'h0B, 8'h92);
        rd_chk("R2 hour reg readback", 8'h0B, 'h92);
        wr(8'h00, 8'hFF);
        rd_chk("R2 ctrl1 only enable bit", 8'h00, 'h02);
        wr(8'h00, 8'h02);

        // R5 minute-only alarm fires at rollover
        set_cal(7'h30, 6'h12, 6'h15, 3'd3);
        setup(8'h30, 8'h80, 8'h80, 8'h80);
        roll();
        check("R5 fire at rollover", alarm_irq, 1);
        rd_chk("R2 flag bit3 set", 8'h01, 'h08);

        // R8 writing 1 keeps, writing 0 clears
        wr(8'h01, 8'h08);
        check("R8 write 1 keeps flag", alarm_irq, 1);
        wr(8'h01, 8'hF7);
        check("R8 write 0 clears flag", alarm_irq, 0);

        // R6 seconds held at zero and advancing within the matching minute
        repeat (4) cyc();
        check("R6 held zero no refire", alarm_irq, 0);
        for (int s = 1; s < 6; s++) begin
            cal_sec = 7'(s); cyc();
        end
        check("R6 seconds advance no refire", alarm_irq, 0);
        wr(8'h01, 8'hFF);
        rd_chk("R8 write 1 with flag clear", 8'h01, 'h00);

        // R3 enabled hour mismatch, then match
        setup(8'h30, 8'h12, 8'h80, 8'h80);
        cal_hour = 6'h13; roll();
        check("R3 hour mismatch no fire", alarm_irq, 0);
        cal_hour = 6'h12; roll();
        check("R3 hour match fires", alarm_irq, 1);

        // R3 disabled field ignored
        setup(8'h30, 8'h85, 8'h80, 8'h80);
        cal_hour = 6'h13; roll();
        check("R3 disabled hour ignored", alarm_irq, 1);

        // R4 hour bit 6 outside compare
        setup(8'h30, 8'h52, 8'h80, 8'h80);
        cal_hour = 6'h12; roll();
        check("R4 hour bit6 ignored", alarm_irq, 1);

        // R4 weekday low three bits
        setup(8'h80, 8'h80, 8'h80, 8'h0D);
        cal_wday = 3'd4; roll();
        check("R4 weekday mismatch", alarm_irq, 0);
        cal_wday = 3'd5; roll();
        check("R4 weekday match", alarm_irq, 1);

        // R4 date only
        setup(8'h80, 8'h80, 8'h15, 8'h80);
        cal_date = 6'h16; roll();
        check("R4 date mismatch", alarm_irq, 0);
        cal_date = 6'h15; roll();
        check("R4 date match", alarm_irq, 1);

        // R7 all fields disabled
        setup(8'h80, 8'h80, 8'h80, 8'h80);
        roll(); roll();
        check("R7 all disabled no fire", alarm_irq, 0);
        rd_chk("R7 flag stays clear", 8'h01, 'h00);

        // R9 enable gating
        wr(8'h00, 8'h00);
        setup(8'h30, 8'h80, 8'h80, 8'h80);
        cal_min = 7'h30; roll();
        check("R9 irq masked", alarm_irq, 0);
        rd_chk("R9 flag set while masked", 8'h01, 'h08);
        wr(8'h00, 8'h02);
        check("R9 irq after enable", alarm_irq, 1);

        // R8 set wins over clear in the same cycle
        cal_sec = 7'h59; cyc();
        cal_sec = 7'h00; reg_wr = 1; reg_addr = 8'h01; reg_wdata = 8'h00;
        cyc();
        reg_wr = 0;
        check("R8 set wins over clear", alarm_irq, 1);

        cyc();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule